// File: doc/BRIEF.md
# Chip-Select Framed Serial Byte Receiver

This block accepts a write-only, clock-synchronous serial stream from a host and turns it into parallel bytes for a controller core. The host pulls chip select low and presents one data bit per serial clock, most significant bit first. It also drives a register-select level that marks the byte as an instruction or as data. The receiver oversamples the serial lines with its own core clock. On every eighth accepted rising edge it issues a one-cycle byte-valid pulse carrying the byte and the register-select flag. That pulse drives the same core write port that a parallel bus front end would use.

Raising chip select abandons any partial byte: the shift register and the bit counter return to zero. While chip select stays low, the bit counter wraps after each byte, so the host can stream bytes back to back without a chip-select toggle. Serial clock, data, chip select and register select each pass through a synchronizer chain. The core clock must run at least four times faster than the serial clock.

Top module: `csf_serial_rx`

## Requirements
- R1: Rising serial clock edges seen while chip select (`cs_n`) is high are ignored: they shift in no bit and produce no byte-valid pulse.
- R2: Chip select high clears the shift register and the bit counter, so a partial byte sent before it is discarded and the next byte assembles from its own first bit.
- R3: Bits are sampled on the rising serial clock edge, and the first bit of a byte becomes bit 7 of `byte_data` and the last becomes bit 0.
- R4: The eighth accepted rising edge produces a byte-valid pulse whose `byte_data` equals the eight bits received.
- R5: `byte_rs` equals the level of `rs_sel` at the eighth rising edge (0 = instruction, 1 = data), regardless of its level during the first seven bits.
- R6: After the eighth bit the bit counter restarts at zero, so consecutive bytes under one chip-select low period are each received correctly.
- R7: `byte_vld` is high for exactly one core clock per byte, and `byte_data` and `byte_rs` stay unchanged until the next pulse.
- R8: After reset, `byte_vld`, `byte_data` and `byte_rs` are all zero.
- R9: With the default two-stage synchronizer, `byte_vld` rises on the third core clock edge after the eighth serial clock rising edge reaches the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| sdi | input | 1 | Serial data, sampled on rising sclk |
| rs_sel | input | 1 | Register select: 0 instruction, 1 data |
| byte_vld | output | 1 | One-cycle pulse: a byte has been received |
| byte_data | output | 8 | Received byte, held until the next pulse |
| byte_rs | output | 1 | Register select latched with the byte |

## Verification
The hardest case to reach from the ports is a partial byte left in the shift register when chip select rises. Without the clear, that residue would shift into the next byte and corrupt it. The bench clocks in five one-bits, raises chip select and then sends a byte whose value exposes any leftover bits. A second directed case toggles the serial clock many times while chip select is high. The stimulus table also changes register select between the seventh and eighth edges, in both directions.

// File: rtl/csf_rx_pkg.sv
package csf_rx_pkg;

   // Asynchronous pin group carried through one synchronizer chain.
   typedef struct packed {
      logic cs_n;
      logic sclk;
      logic sdi;
      logic rs;
   } csf_pins_t;

   localparam int unsigned CSF_PIN_W = $bits(csf_pins_t);

   // Idle value: deselected, clock high, data low, instruction.
   localparam csf_pins_t CSF_PIN_IDLE = '{cs_n: 1'b1, sclk: 1'b1, sdi: 1'b0, rs: 1'b0};

endpackage

// File: rtl/csf_sync.sv
module csf_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("csf_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("csf_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[i] <= RST_VAL;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/csf_edge_det.sv
module csf_edge_det #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   input  logic enable,
   output logic pulse
);

   localparam logic PREV_RST = RISING ? 1'b1 : 1'b0;

   logic prev_q;
   logic raw_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= PREV_RST;
      else        prev_q <= sig;
   end

   generate
      if (RISING) begin : g_rise
         assign raw_edge = sig & ~prev_q;
      end else begin : g_fall
         assign raw_edge = ~sig & prev_q;
      end
   endgenerate

   assign pulse = raw_edge & enable;

   AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse); // R4

endmodule

// File: rtl/csf_shifter.sv
module csf_shifter #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift_en,
   input  logic              bit_in,
   input  logic              rs_in,
   output logic              vld,
   output logic [DATA_W-1:0] data,
   output logic              rs_flag
);

   localparam int unsigned   CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("csf_shifter: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] shift_q;
   logic [DATA_W-1:0] shift_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic              last_bit;

   generate
      if (MSB_FIRST) begin : g_msb
         assign shift_nxt = {shift_q[DATA_W-2:0], bit_in};
      end else begin : g_lsb
         assign shift_nxt = {bit_in, shift_q[DATA_W-1:1]};
      end
   endgenerate

   assign last_bit = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         cnt_q   <= '0;
         vld     <= 1'b0;
         data    <= '0;
         rs_flag <= 1'b0;
      end else begin
         vld <= 1'b0;
         if (clr) begin
            shift_q <= '0;
            cnt_q   <= '0;
         end else if (shift_en) begin
            shift_q <= shift_nxt;
            if (last_bit) begin
               cnt_q   <= '0;
               vld     <= 1'b1;
               data    <= shift_nxt;
               rs_flag <= rs_in;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0) && (shift_q == '0)); // R2

   AST_CNT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      vld |-> (cnt_q == '0)); // R6

   AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      vld |=> !vld); // R7

   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |-> ($stable(data) && $stable(rs_flag))); // R7

endmodule

// File: rtl/csf_serial_rx.sv
module csf_serial_rx #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   input  logic              rs_sel,
   output logic              byte_vld,
   output logic [DATA_W-1:0] byte_data,
   output logic              byte_rs
);

   import csf_rx_pkg::*;

   csf_pins_t pins_raw;
   csf_pins_t pins_s;
   logic      sclk_rise;

   assign pins_raw = '{cs_n: cs_n, sclk: sclk, sdi: sdi, rs: rs_sel};

   csf_sync #(
      .W       (CSF_PIN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (CSF_PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   csf_edge_det #(
      .RISING (1'b1)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig    (pins_s.sclk),
      .enable (~pins_s.cs_n),
      .pulse  (sclk_rise)
   );

   csf_shifter #(
      .DATA_W    (DATA_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (pins_s.cs_n),
      .shift_en (sclk_rise),
      .bit_in   (pins_s.sdi),
      .rs_in    (pins_s.rs),
      .vld      (byte_vld),
      .data     (byte_data),
      .rs_flag  (byte_rs)
   );

   AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      pins_s.cs_n |=> !byte_vld); // R1

   AST_RS_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> (byte_rs == $past(pins_s.rs))); // R5

endmodule

// File: tb/tb_csf_serial_rx.sv
module tb_csf_serial_rx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic       sdi = 1'b0;
   logic       rs_sel = 1'b0;
   logic       byte_vld;
   logic [7:0] byte_data;
   logic       byte_rs;

   int n_chk = 0;
   int n_bad = 0;
   int n_pulse = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   csf_serial_rx dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .sclk      (sclk),
      .sdi       (sdi),
      .rs_sel    (rs_sel),
      .byte_vld  (byte_vld),
      .byte_data (byte_data),
      .byte_rs   (byte_rs)
   );

   always @(posedge clk) if (rst_n && byte_vld) n_pulse++;

   // {new_frame, rs_at_last_bit, rs_during_first_seven, data}
   localparam int NV = 7;
   localparam logic [10:0] VEC [NV] = '{
      {1'b1, 1'b0, 1'b0, 8'hA5},
      {1'b0, 1'b1, 1'b1, 8'h5A},
      {1'b0, 1'b0, 1'b1, 8'hFF},
      {1'b0, 1'b1, 1'b0, 8'h00},
      {1'b1, 1'b1, 1'b1, 8'h80},
      {1'b0, 1'b0, 1'b0, 8'h01},
      {1'b1, 1'b1, 1'b0, 8'hC3}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic frame_restart();
      @(negedge clk);
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // Sends one byte MSB first; checks pulse timing, data and flag (R3 R4 R5 R9 R7).
   task automatic send_byte(input logic [7:0] b, input logic rs_early, input logic rs_last);
      int p0;
      p0 = n_pulse;
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk);
         sclk   = 1'b0;
         sdi    = b[i];
         rs_sel = (i == 0) ? rs_last : rs_early;
         repeat (7) @(negedge clk);
         sclk = 1'b1;
         if (i != 0) begin
            repeat (7) @(negedge clk);
         end else begin
            @(negedge clk); chk("R9 no pulse one edge after", 32'(byte_vld), 32'd0);
            @(negedge clk); chk("R9 no pulse two edges after", 32'(byte_vld), 32'd0);
            @(negedge clk); chk("R9 pulse on third edge", 32'(byte_vld), 32'd1);
            chk("R3 R4 byte value", 32'(byte_data), 32'(b));
            chk("R5 flag at eighth edge", 32'(byte_rs), 32'(rs_last));
            @(negedge clk); chk("R7 pulse one cycle", 32'(byte_vld), 32'd0);
            repeat (3) @(negedge clk);
         end
      end
      chk("R4 one pulse per byte", 32'(n_pulse - p0), 32'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int p0;
      repeat (3) @(negedge clk);
      chk("R8 vld after reset", 32'(byte_vld), 32'd0);
      chk("R8 data after reset", 32'(byte_data), 32'd0);
      chk("R8 flag after reset", 32'(byte_rs), 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // Table walk: framed and back-to-back bytes (R6), rs changes late (R5).
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int v = 0; v < NV; v++) begin
         if (VEC[v][10]) frame_restart();
         send_byte(VEC[v][7:0], VEC[v][8], VEC[v][9]);
      end
      chk("R6 table pulse count", 32'(n_pulse), 32'(NV));

      // R7: outputs held long after the pulse.
      repeat (40) @(negedge clk);
      chk("R7 data held", 32'(byte_data), 32'hC3);
      chk("R7 flag held", 32'(byte_rs), 32'd1);
      chk("R7 vld low while idle", 32'(byte_vld), 32'd0);

      // R2: abort a partial byte of ones, then send a fresh byte.
      p0 = n_pulse;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); sclk = 1'b0; sdi = 1'b1;
         repeat (7) @(negedge clk); sclk = 1'b1;
         repeat (7) @(negedge clk);
      end
      chk("R2 partial byte no pulse", 32'(n_pulse - p0), 32'd0);
      frame_restart();
      send_byte(8'h81, 1'b0, 1'b0);
      chk("R2 fresh byte after abort", 32'(byte_data), 32'h81);

      // R1: serial clocks while deselected are ignored.
      @(negedge clk);
      cs_n = 1'b1;
      p0 = n_pulse;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk); sclk = 1'b0; sdi = 1'b1;
         repeat (5) @(negedge clk); sclk = 1'b1;
         repeat (5) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      chk("R1 no pulse while deselected", 32'(n_pulse - p0), 32'd0);
      chk("R1 data untouched", 32'(byte_data), 32'h81);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      send_byte(8'h3C, 1'b0, 1'b1);
      chk("R1 byte after deselected clocks", 32'(byte_data), 32'h3C);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule